// File: doc/BRIEF.md
# Low-Power Coprocessor Execution Core

This block is a small multicycle processor core that runs tiny background programs while the main system sleeps. Every instruction is one 32-bit word. The core has four 16-bit general registers, an ALU that keeps a zero flag and an overflow flag, absolute and relative branches, word-addressed load and store, a programmable stall, and a halt. Program and data share one synchronous memory port with single-cycle read latency, and the core issues one access per cycle at most.

A wake-up timer starts the core with a one-cycle start pulse that carries the first program address. The core then fetches and executes one instruction at a time until it meets a halt. On the way it can tell the timer to wake the system or to pick a different sleep interval. Measurement and bus instructions that this core does not implement run as no-ops.

Top module: `lpcore_top`

## Requirements
- R1: After synchronous reset the core is idle (running low), issues no memory read or write, drives no events, and all four registers and both flags are zero.
- R2: A start pulse while idle makes the core fetch its first instruction at start_pc. A start pulse while the core is running has no effect.
- R3: The major opcode is in bits [31:28]. Opcode 7 is the ALU, with the sub-opcode in [27:25], the operation in [24:21], the destination register in [1:0] and source A in [3:2]. Sub-opcode 0 takes operand B from the register in [5:4]. Sub-opcode 1 takes operand B from the immediate in [19:4]. The operations are 0 add, 1 subtract, 2 AND, 3 OR, 4 move, 5 shift left and 6 shift right. A register move copies source A and an immediate move copies the immediate. Shifts use only the low 4 bits of operand B.
- R4: Zero is set when the ALU result is zero. Overflow is the carry out of an add or the borrow out of a subtract, and every other ALU operation clears it. No instruction other than an ALU instruction changes either flag.
- R5: Opcode 8 with sub-opcode 0 is an absolute branch. The condition in [24:22] is 0 always, 1 if zero is set, or 2 if overflow is set. The target is bits [12:2], or, when bit 21 is set, the low 11 bits of the register in [1:0].
- R6: Opcode 8 with sub-opcode 1 is a relative branch. It compares R0 unsigned with the immediate in [15:0]. Bit 16 chooses less-than (0) or greater-or-equal (1). When the condition holds, the target is PC plus the magnitude in [23:17], or PC minus it when bit 24 is set.
- R7: Opcode 13 loads from word address (register [3:2] + offset [20:10]), modulo 2048. Only the low 16 bits of the word go into the register in [1:0].
- R8: Opcode 6 stores to the same address form. It writes a word with the register in [1:0] in bits [15:0], the 11-bit PC of the store in bits [26:16], and zero in bits [31:27].
- R9: Opcode 4 stalls for exactly the count in bits [15:0] of extra cycles, with no memory access during the stall. A count of zero adds nothing.
- R10: Opcode 11 stops the core and pulses halt_evt for one cycle. Opcode 9 with sub-opcode 0 pulses end_evt, with wake_evt equal to bit 0. Opcode 9 with sub-opcode 1 pulses sleep_evt and loads sleep_sel from bits [3:0]. The end and sleep forms both continue execution.
- R11: Any other opcode is a no-op: the PC advances by one word and no register, flag or memory word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle start request |
| start_pc | input | 11 | Word address of the first instruction |
| mem_addr | output | 11 | Shared memory word address |
| mem_re | output | 1 | Memory read; data returns the next cycle |
| mem_we | output | 1 | Memory write |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| running | output | 1 | Core is executing a program |
| halt_evt | output | 1 | One-cycle pulse when a halt retires |
| end_evt | output | 1 | One-cycle pulse for an end instruction |
| wake_evt | output | 1 | Wake request, valid with end_evt |
| sleep_evt | output | 1 | One-cycle pulse for a sleep-select instruction |
| sleep_sel | output | 4 | Last selected sleep interval index |

## Verification
The bench aims at flag lifetime. A load and a branch placed between an ALU result and the conditional branch that tests it would expose a core that clobbers the flags outside the ALU, and a move after an add with carry catches overflow that is never cleared. Relative branches are tested with a backward loop and at the exact equality boundary of the unsigned compare, where a wrong sign or a swapped compare sense changes the stored loop count. Shift amounts above 15 check that only four bits are used. The stored PC field checks both the store format and the start address. A stall's cost is measured as a cycle difference against a zero-count stall, and a start pulse that arrives mid-stall would divert the program if the core did not ignore it.

// File: rtl/lpcore_pkg.sv
package lpcore_pkg;

    localparam int IW      = 32;
    localparam int REG_W   = 16;
    localparam int PC_W    = 11;
    localparam int NREG    = 4;
    localparam int RSEL_W  = $clog2(NREG);
    localparam int SHAMT_W = $clog2(REG_W);
    localparam int DLY_W   = 16;
    localparam int MAG_W   = 7;

    localparam logic [3:0] OPC_DELAY  = 4'd4;
    localparam logic [3:0] OPC_STORE  = 4'd6;
    localparam logic [3:0] OPC_ALU    = 4'd7;
    localparam logic [3:0] OPC_BRANCH = 4'd8;
    localparam logic [3:0] OPC_EVENT  = 4'd9;
    localparam logic [3:0] OPC_HALT   = 4'd11;
    localparam logic [3:0] OPC_LOAD   = 4'd13;

    typedef enum logic [3:0] {
        ALU_ADD = 4'd0,
        ALU_SUB = 4'd1,
        ALU_AND = 4'd2,
        ALU_OR  = 4'd3,
        ALU_MOV = 4'd4,
        ALU_SHL = 4'd5,
        ALU_SHR = 4'd6
    } alu_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_LDWAIT,
        ST_DELAY
    } core_state_e;

    typedef struct packed {
        logic [REG_W-1:0] value;
        logic             zero;
        logic             ovf;
    } alu_out_t;

    function automatic logic alu_op_valid(input logic [3:0] sel);
        return sel <= 4'd6;
    endfunction

endpackage

// File: rtl/lpcore_regfile.sv
module lpcore_regfile
    import lpcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RSEL_W-1:0] waddr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [RSEL_W-1:0] ra_a,
    input  logic [RSEL_W-1:0] ra_b,
    input  logic [RSEL_W-1:0] ra_c,
    output logic [REG_W-1:0]  rd_a,
    output logic [REG_W-1:0]  rd_b,
    output logic [REG_W-1:0]  rd_c,
    output logic [REG_W-1:0]  rd_zero
);
    logic [REG_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && waddr == RSEL_W'(i))
                regs[i] <= wdata;
        end
    end

    assign rd_a    = regs[ra_a];
    assign rd_b    = regs[ra_b];
    assign rd_c    = regs[ra_c];
    assign rd_zero = regs[0];

    // R3: a write lands in the selected register on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/lpcore_alu.sv
module lpcore_alu
    import lpcore_pkg::*;
(
    input  logic [REG_W-1:0] opa,
    input  logic [REG_W-1:0] opb,
    input  logic [3:0]       sel,
    output alu_out_t         res
);
    logic [REG_W:0]       wide;
    logic [SHAMT_W-1:0]   shamt;

    assign shamt = opb[SHAMT_W-1:0];

    always_comb begin
        wide = '0;
        case (sel)
            ALU_ADD: wide = {1'b0, opa} + {1'b0, opb};
            ALU_SUB: wide = {1'b0, opa} - {1'b0, opb};
            ALU_AND: wide = {1'b0, opa & opb};
            ALU_OR:  wide = {1'b0, opa | opb};
            ALU_MOV: wide = {1'b0, opb};
            ALU_SHL: wide = {1'b0, opa << shamt};
            ALU_SHR: wide = {1'b0, opa >> shamt};
            default: wide = {1'b0, opa};
        endcase
        res.value = wide[REG_W-1:0];
        res.zero  = (wide[REG_W-1:0] == '0);
        res.ovf   = wide[REG_W];
    end
endmodule

// File: rtl/lpcore_branch.sv
module lpcore_branch
    import lpcore_pkg::*;
(
    input  logic [2:0]       sub,
    input  logic [2:0]       cond,
    input  logic             use_reg,
    input  logic [PC_W-1:0]  abs_addr,
    input  logic [PC_W-1:0]  reg_target,
    input  logic             rel_neg,
    input  logic [MAG_W-1:0] rel_mag,
    input  logic             rel_ge,
    input  logic [REG_W-1:0] rel_imm,
    input  logic [REG_W-1:0] r0,
    input  logic [PC_W-1:0]  pc,
    input  logic             zflag,
    input  logic             oflag,
    output logic             take,
    output logic [PC_W-1:0]  target
);
    logic lt;

    assign lt = r0 < rel_imm;

    always_comb begin
        take   = 1'b0;
        target = pc;
        case (sub)
            3'd0: begin
                target = use_reg ? reg_target : abs_addr;
                case (cond)
                    3'd0:    take = 1'b1;
                    3'd1:    take = zflag;
                    3'd2:    take = oflag;
                    default: take = 1'b0;
                endcase
            end
            3'd1: begin
                take   = rel_ge ? !lt : lt;
                target = rel_neg ? pc - PC_W'(rel_mag) : pc + PC_W'(rel_mag);
            end
            default: take = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpcore_top.sv
module lpcore_top
    import lpcore_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PC_W-1:0] start_pc,
    output logic [PC_W-1:0] mem_addr,
    output logic            mem_re,
    output logic            mem_we,
    output logic [IW-1:0]   mem_wdata,
    input  logic [IW-1:0]   mem_rdata,
    output logic            running,
    output logic            halt_evt,
    output logic            end_evt,
    output logic            wake_evt,
    output logic            sleep_evt,
    output logic [3:0]      sleep_sel
);
    core_state_e      state;
    logic [PC_W-1:0]  pc;
    logic [IW-1:0]    ir;
    logic             zf, of;
    logic [DLY_W-1:0] dcnt;

    logic [3:0] opc;
    logic [2:0] sub;
    logic [3:0] asel;
    logic       alu_ok, exec;

    logic [REG_W-1:0] rd_a, rd_b, rd_c, r0;
    logic [REG_W-1:0] opb;
    logic             rf_we;
    logic [REG_W-1:0] rf_wdata;
    alu_out_t         alu_res;
    logic             br_take;
    logic [PC_W-1:0]  br_target;
    logic [PC_W-1:0]  ea;
    logic [PC_W-1:0]  pc_next;

    assign opc     = ir[31:28];
    assign sub     = ir[27:25];
    assign asel    = ir[24:21];
    assign exec    = (state == ST_EXEC);
    assign alu_ok  = (opc == OPC_ALU) && (sub <= 3'd1) && alu_op_valid(asel);
    assign running = (state != ST_IDLE);
    assign pc_next = pc + PC_W'(1);
    assign ea      = rd_a[PC_W-1:0] + ir[20:10];

    assign opb = (sub == 3'd1) ? ir[19:4]
               : (asel == ALU_MOV) ? rd_a : rd_b;

    assign rf_we    = (exec && alu_ok) || (state == ST_LDWAIT);
    assign rf_wdata = (state == ST_LDWAIT) ? mem_rdata[REG_W-1:0] : alu_res.value;

    lpcore_regfile u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .waddr   (ir[1:0]),
        .wdata   (rf_wdata),
        .ra_a    (ir[3:2]),
        .ra_b    (ir[5:4]),
        .ra_c    (ir[1:0]),
        .rd_a    (rd_a),
        .rd_b    (rd_b),
        .rd_c    (rd_c),
        .rd_zero (r0)
    );

    lpcore_alu u_alu (
        .opa (rd_a),
        .opb (opb),
        .sel (asel),
        .res (alu_res)
    );

    lpcore_branch u_br (
        .sub        (sub),
        .cond       (ir[24:22]),
        .use_reg    (ir[21]),
        .abs_addr   (ir[12:2]),
        .reg_target (rd_c[PC_W-1:0]),
        .rel_neg    (ir[24]),
        .rel_mag    (ir[23:17]),
        .rel_ge     (ir[16]),
        .rel_imm    (ir[15:0]),
        .r0         (r0),
        .pc         (pc),
        .zflag      (zf),
        .oflag      (of),
        .take       (br_take),
        .target     (br_target)
    );

    // memory port steering
    always_comb begin
        mem_addr  = pc;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = '0;
        if (state == ST_FETCH) begin
            mem_re = 1'b1;
        end else if (exec && opc == OPC_LOAD) begin
            mem_addr = ea;
            mem_re   = 1'b1;
        end else if (exec && opc == OPC_STORE) begin
            mem_addr  = ea;
            mem_we    = 1'b1;
            mem_wdata = {{(IW-REG_W-PC_W){1'b0}}, pc, rd_c};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pc        <= '0;
            ir        <= '0;
            zf        <= 1'b0;
            of        <= 1'b0;
            dcnt      <= '0;
            halt_evt  <= 1'b0;
            end_evt   <= 1'b0;
            wake_evt  <= 1'b0;
            sleep_evt <= 1'b0;
            sleep_sel <= '0;
        end else begin
            halt_evt  <= 1'b0;
            end_evt   <= 1'b0;
            wake_evt  <= 1'b0;
            sleep_evt <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc    <= start_pc;
                        state <= ST_FETCH;
                    end
                end
                ST_FETCH: state <= ST_LATCH;
                ST_LATCH: begin
                    ir    <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    pc    <= pc_next;
                    state <= ST_FETCH;
                    case (opc)
                        OPC_ALU: begin
                            if (alu_ok) begin
                                zf <= alu_res.zero;
                                of <= ((asel == ALU_ADD) || (asel == ALU_SUB)) && alu_res.ovf;
                            end
                        end
                        OPC_BRANCH: begin
                            if (br_take) pc <= br_target;
                        end
                        OPC_LOAD: begin
                            pc    <= pc;
                            state <= ST_LDWAIT;
                        end
                        OPC_DELAY: begin
                            if (ir[DLY_W-1:0] != '0) begin
                                pc    <= pc;
                                dcnt  <= ir[DLY_W-1:0];
                                state <= ST_DELAY;
                            end
                        end
                        OPC_EVENT: begin
                            if (sub == 3'd0) begin
                                end_evt  <= 1'b1;
                                wake_evt <= ir[0];
                            end else if (sub == 3'd1) begin
                                sleep_evt <= 1'b1;
                                sleep_sel <= ir[3:0];
                            end
                        end
                        OPC_HALT: begin
                            pc       <= pc;
                            halt_evt <= 1'b1;
                            state    <= ST_IDLE;
                        end
                        default: ;
                    endcase
                end
                ST_LDWAIT: begin
                    pc    <= pc_next;
                    state <= ST_FETCH;
                end
                ST_DELAY: begin
                    dcnt <= dcnt - DLY_W'(1);
                    if (dcnt == DLY_W'(1)) begin
                        pc    <= pc_next;
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: an idle core leaves memory alone
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!mem_re && !mem_we));

    // R2: the core only begins running in response to a start pulse
    a_r2_start_only: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(start));

    // R4: flags move only when an ALU instruction executes
    a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !(exec && alu_ok) |=> ($stable(zf) && $stable(of)));

    // R8: a store is a single write cycle followed by the next fetch
    a_r8_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_re && !mem_we));

    // R9: the PC is frozen while a stall is still counting
    a_r9_stall_holds_pc: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY && dcnt != DLY_W'(1)) |=> (state == ST_DELAY && $stable(pc)));

    // R10: at most one event kind per cycle, and halt leaves the core idle
    a_r10_events_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({halt_evt, end_evt, sleep_evt}));
    a_r10_halt_idle: assert property (@(posedge clk) disable iff (rst)
        halt_evt |-> !running);
endmodule

// File: tb/lpcore_top_bench.sv
`timescale 1ns/1ps
module lpcore_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [10:0] start_pc = '0;
    logic [10:0] mem_addr;
    logic        mem_re, mem_we;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        running, halt_evt, end_evt, wake_evt, sleep_evt;
    logic [3:0]  sleep_sel;

    int n_checks = 0;
    int n_fail   = 0;
    int halt_cnt = 0, end_cnt = 0, wake_cnt = 0, sleep_cnt = 0;
    logic [31:0] mem [2048];

    always #2.5 clk = ~clk;

    lpcore_top u_lpcore_top (
        .clk(clk), .rst(rst), .start(start), .start_pc(start_pc),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .running(running), .halt_evt(halt_evt), .end_evt(end_evt),
        .wake_evt(wake_evt), .sleep_evt(sleep_evt), .sleep_sel(sleep_sel)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (halt_evt)  halt_cnt  <= halt_cnt + 1;
        if (end_evt)   end_cnt   <= end_cnt + 1;
        if (end_evt && wake_evt) wake_cnt <= wake_cnt + 1;
        if (sleep_evt) sleep_cnt <= sleep_cnt + 1;
    end

    // instruction encoders
    function automatic logic [31:0] e_alui(input int sel, input int d, input int s, input int imm);
        return {4'd7, 3'd1, 4'(sel), 1'b0, 16'(imm), 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_alur(input int sel, input int d, input int s, input int t);
        return {4'd7, 3'd0, 4'(sel), 15'd0, 2'(t), 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_bx(input int cond, input int regf, input int addr, input int r);
        return {4'd8, 3'd0, 3'(cond), 1'(regf), 8'd0, 11'(addr), 2'(r)};
    endfunction
    function automatic logic [31:0] e_brel(input int off, input int ge, input int imm);
        logic neg;
        int   mag;
        neg = off < 0;
        mag = neg ? -off : off;
        return {4'd8, 3'd1, neg, 7'(mag), 1'(ge), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_st(input int d, input int s, input int off);
        return {4'd6, 3'd4, 4'd0, 11'(off), 6'd0, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_ld(input int d, input int s, input int off);
        return {4'd13, 7'd0, 11'(off), 6'd0, 2'(s), 2'(d)};
    endfunction
    function automatic logic [31:0] e_dly(input int n);
        return {4'd4, 12'd0, 16'(n)};
    endfunction
    function automatic logic [31:0] e_end(input int w);
        return {4'd9, 3'd0, 24'd0, 1'(w)};
    endfunction
    function automatic logic [31:0] e_slp(input int c);
        return {4'd9, 3'd1, 21'd0, 4'(c)};
    endfunction
    function automatic logic [31:0] e_halt();
        return {4'd11, 28'd0};
    endfunction
    function automatic logic [31:0] stw(input int pc, input int val);
        return {5'd0, 11'(pc), 16'(val)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_prog(input int spc, output int cycles);
        int h0;
        h0 = halt_cnt;
        @(negedge clk);
        start = 1'b1;
        start_pc = 11'(spc);
        @(negedge clk);
        start = 1'b0;
        cycles = 0;
        while (halt_cnt == h0 && cycles < 5000) begin
            @(negedge clk);
            cycles++;
        end
        chk("R10 halt reached", 32'(halt_cnt - h0), 32'd1);
    endtask

    task automatic t_reset();
        int c;
        chk("R1 running", {31'd0, running}, 32'd0);
        chk("R1 mem idle", {30'd0, mem_re, mem_we}, 32'd0);
        chk("R1 events", {28'd0, halt_evt, end_evt, sleep_evt, wake_evt}, 32'd0);
        mem[140] = e_st(3, 1, 11'h450);
        mem[141] = e_bx(1, 0, 143, 0);
        mem[142] = e_st(2, 1, 11'h451);
        mem[143] = e_halt();
        run_prog(140, c);
        chk("R1 regs zero", mem[11'h450], stw(140, 0));
        chk("R1 zero flag clear", mem[11'h451], stw(142, 0));
    endtask

    task automatic t_alu();
        int c;
        mem[0]  = e_alui(4, 1, 0, 16'h1234);
        mem[1]  = e_alui(4, 2, 0, 4);
        mem[2]  = e_alur(5, 3, 1, 2);
        mem[3]  = e_alui(4, 0, 0, 11'h400);
        mem[4]  = e_st(3, 0, 0);
        mem[5]  = e_alui(6, 3, 1, 16'h0014);
        mem[6]  = e_st(3, 0, 1);
        mem[7]  = e_alur(1, 3, 1, 2);
        mem[8]  = e_st(3, 0, 2);
        mem[9]  = e_alui(2, 3, 1, 16'h0F0F);
        mem[10] = e_st(3, 0, 3);
        mem[11] = e_alui(3, 3, 1, 16'h4001);
        mem[12] = e_st(3, 0, 4);
        mem[13] = e_alur(4, 3, 2, 0);
        mem[14] = e_st(3, 0, 5);
        mem[15] = e_alur(0, 3, 1, 2);
        mem[16] = e_st(3, 0, 6);
        mem[17] = e_halt();
        run_prog(0, c);
        chk("R3 shl reg", mem[11'h400], stw(4, 16'h2340));
        chk("R3 shr imm low4", mem[11'h401], stw(6, 16'h0123));
        chk("R3 sub reg", mem[11'h402], stw(8, 16'h1230));
        chk("R3 and imm", mem[11'h403], stw(10, 16'h0204));
        chk("R3 or imm", mem[11'h404], stw(12, 16'h5235));
        chk("R3 mov reg", mem[11'h405], stw(14, 4));
        chk("R8 add reg store word", mem[11'h406], stw(16, 16'h1238));
    endtask

    task automatic t_flags();
        int c;
        mem[11'h41F] = {16'hABCD, 16'd56};
        mem[11'h410] = 32'hDEADBEEF;
        mem[11'h411] = 32'hDEADBEEF;
        mem[11'h416] = 32'hDEADBEEF;
        mem[32] = e_alui(4, 0, 0, 11'h410);
        mem[33] = e_alui(4, 1, 0, 16'hFFFF);
        mem[34] = e_alui(0, 1, 1, 1);
        mem[35] = e_ld(2, 0, 15);
        mem[36] = e_bx(1, 0, 39, 0);
        mem[37] = e_alui(4, 3, 0, 16'hBAD);
        mem[38] = e_st(3, 0, 0);
        mem[39] = e_bx(2, 0, 42, 0);
        mem[40] = e_alui(4, 3, 0, 16'hBAD);
        mem[41] = e_st(3, 0, 1);
        mem[42] = e_alui(1, 3, 1, 1);
        mem[43] = e_st(3, 0, 2);
        mem[44] = e_bx(1, 0, 47, 0);
        mem[45] = e_alui(4, 3, 0, 16'h55);
        mem[46] = e_st(3, 0, 3);
        mem[47] = e_bx(2, 0, 50, 0);
        mem[48] = e_alui(4, 3, 0, 16'h66);
        mem[49] = e_st(3, 0, 4);
        mem[50] = e_alui(1, 3, 3, 16'h66);
        mem[51] = e_bx(2, 0, 54, 0);
        mem[52] = e_st(3, 0, 5);
        mem[53] = e_bx(0, 1, 0, 2);
        mem[54] = e_alui(4, 3, 0, 16'hBAD);
        mem[55] = e_st(3, 0, 6);
        mem[56] = e_st(2, 0, 7);
        mem[57] = e_halt();
        run_prog(32, c);
        chk("R4 R5 zero branch after load taken", mem[11'h410], 32'hDEADBEEF);
        chk("R4 R5 carry branch taken", mem[11'h411], 32'hDEADBEEF);
        chk("R4 borrow result", mem[11'h412], stw(43, 16'hFFFF));
        chk("R5 zero branch not taken", mem[11'h413], stw(46, 16'h55));
        chk("R4 mov clears overflow", mem[11'h414], stw(49, 16'h66));
        chk("R4 sub no borrow", mem[11'h415], stw(52, 0));
        chk("R5 register target taken", mem[11'h416], 32'hDEADBEEF);
        chk("R7 load low half", mem[11'h417], stw(56, 56));
    endtask

    task automatic t_rel();
        int c;
        mem[11'h421] = 32'hDEADBEEF;
        mem[64] = e_alui(4, 1, 0, 11'h420);
        mem[65] = e_alui(4, 0, 0, 0);
        mem[66] = e_alui(0, 0, 0, 1);
        mem[67] = e_brel(-1, 0, 5);
        mem[68] = e_st(0, 1, 0);
        mem[69] = e_brel(3, 1, 5);
        mem[70] = e_alui(4, 3, 0, 16'hBAD);
        mem[71] = e_st(3, 1, 1);
        mem[72] = e_brel(3, 0, 5);
        mem[73] = e_st(0, 1, 2);
        mem[74] = e_halt();
        run_prog(64, c);
        chk("R6 backward loop count", mem[11'h420], stw(68, 5));
        chk("R6 ge at equality taken", mem[11'h421], 32'hDEADBEEF);
        chk("R6 lt at equality not taken", mem[11'h422], stw(73, 5));
    endtask

    task automatic t_delay();
        int c0, c1;
        mem[96]  = e_dly(0);
        mem[97]  = e_halt();
        mem[100] = e_dly(37);
        mem[101] = e_halt();
        run_prog(96, c0);
        run_prog(100, c1);
        chk("R9 stall length", 32'(c1 - c0), 32'd37);
    endtask

    task automatic t_events();
        int c, e0, w0, s0;
        e0 = end_cnt; w0 = wake_cnt; s0 = sleep_cnt;
        mem[112] = e_end(1);
        mem[113] = e_slp(3);
        mem[114] = {4'd5, 28'hFFFFFFF};
        mem[115] = {4'd3, 28'h0000003};
        mem[116] = e_alui(4, 1, 0, 11'h430);
        mem[117] = e_alui(4, 2, 0, 16'h77);
        mem[118] = e_st(2, 1, 0);
        mem[119] = e_end(0);
        mem[120] = e_halt();
        run_prog(112, c);
        chk("R10 end pulses", 32'(end_cnt - e0), 32'd2);
        chk("R10 wake pulses", 32'(wake_cnt - w0), 32'd1);
        chk("R10 sleep pulses", 32'(sleep_cnt - s0), 32'd1);
        chk("R10 sleep select", {28'd0, sleep_sel}, 32'd3);
        chk("R11 no-op opcodes continue", mem[11'h430], stw(118, 16'h77));
    endtask

    task automatic t_start_ignored();
        int h0, n;
        mem[11'h406] = 32'h0;
        mem[128] = e_dly(50);
        mem[129] = e_alui(4, 1, 0, 11'h440);
        mem[130] = e_alui(4, 2, 0, 16'h99);
        mem[131] = e_st(2, 1, 0);
        mem[132] = e_halt();
        h0 = halt_cnt;
        @(negedge clk);
        start = 1'b1; start_pc = 11'd128;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        start = 1'b1; start_pc = 11'd0;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (halt_cnt == h0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
        chk("R2 single program run", 32'(halt_cnt - h0), 32'd1);
        chk("R2 start pc honoured", mem[11'h440], stw(131, 16'h99));
        chk("R2 mid-run start ignored", mem[11'h406], 32'h0);
        chk("R2 idle after halt", {31'd0, running}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_alu();
        t_flags();
        t_rel();
        t_delay();
        t_events();
        t_start_ignored();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule